// File: doc/BRIEF.md
# I2C Message-List Transfer Sequencer

This block runs a list of I2C messages on top of a byte-level I2C master engine. The engine handles the bus itself. It reports each finished bus step as an 8-bit status code with a one-cycle strobe, and it accepts single-cycle commands: start, send a byte, receive a byte with a chosen acknowledge, stop, reset and configure. The sequencer chooses every command from the last status code alone. It builds address bytes, walks the message buffers, plans the acknowledge for each received byte so that only the last byte of a read is refused, and puts a repeated start between messages and a stop after the last one.

Each message is described by a 7-bit target address, a direction bit and a byte length, all presented as flat vectors. Message `i` uses the byte buffer window that starts at `i*MAX_LEN`. The host fills write data and reads back received data through a small local memory port. A `go` pulse starts the run. A `done` pulse ends it with a result class and the number of messages completed. Every kind of failure has its own result class.

Top module: `i2c_msg_seq`

## Requirements
- R1: After reset, `busy`, `done` and `cmd_vld` are low, and `res_code` and `res_count` are zero.
- R2: After `go`, no command is issued until `eng_status` is 0xF8. If 0xF8 is not seen within IDLE_TMO cycles, the run ends with `res_code` 1, `res_count` 0 and no command issued. A later 0xF8 inside the window starts the run normally.
- R3: Command encoding on `cmd_op`: 1 start, 2 send `cmd_data`, 3 receive with acknowledge `cmd_ack`, 4 stop, 5 reset, 6 configure. The first command on idle is a start. On status 0x08 or 0x10 the sequencer sends `{address, rd}`, with the direction in bit 0 (1 = read).
- R4: On status 0x18 or 0x28, while bytes remain, the next write byte is sent from buffer address `msg*MAX_LEN + index`. A zero-length write sends only its address and then moves on.
- R5: When a message completes and more messages follow, a start (repeated start) is issued. After the last message a stop is issued and the run ends with `res_code` 0 and `res_count` equal to `num_msgs`.
- R6: On status 0x40 the receive command acknowledges only if the length is above one. On 0x50 the byte in `eng_rdata` is stored and the next receive acknowledges only while more than one byte remains. On 0x58 for the final byte, that byte is stored. Stored bytes can be read at `msg*MAX_LEN + index` through `buf_rdata`.
- R7: Status 0x58 for a byte that is not the last of its message causes a stop and `res_code` 4. That byte is not stored.
- R8: Address refusal (0x20 or 0x48) causes a stop and `res_code` 2, with `res_count` equal to the number of messages already completed.
- R9: Data refusal (0x30) causes a stop and `res_code` 3.
- R10: Arbitration loss (0x38) causes a start request and `res_code` 5.
- R11: A bus-error status (0x00, 0x70, 0x78 or 0x90) causes a reset command, followed on the very next cycle by a configure command carrying CFG_WORD. The run ends with `res_code` 6.
- R12: An unrecognised status produces no command. If the run has not finished XFER_TMO cycles after its first start, it ends with `res_code` 7. Send and receive commands are only issued in reaction to a status strobe.
- R13: `done` lasts exactly one cycle, with `busy` low. The result stays on `res_code` and `res_count` until the next run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| go | input | 1 | Start a run of the message list (ignored while busy) |
| num_msgs | input | MW | Number of messages in the list (at most MAX_MSGS), held during a run |
| msg_addr | input | MAX_MSGS*7 | 7-bit target address of each message |
| msg_rd | input | MAX_MSGS | Direction of each message, 1 = read |
| msg_len | input | MAX_MSGS*LW | Byte length of each message (at most MAX_LEN) |
| buf_we | input | 1 | Host write strobe for the byte buffer (taken when idle) |
| buf_addr | input | AW | Host buffer address |
| buf_wdata | input | 8 | Host write data |
| buf_rdata | output | 8 | Buffer contents at `buf_addr` |
| eng_status | input | 8 | Engine status code |
| eng_si | input | 1 | One-cycle strobe: a new status is present |
| eng_rdata | input | 8 | Byte received by the engine |
| cmd_vld | output | 1 | One-cycle command strobe |
| cmd_op | output | 3 | Command code |
| cmd_ack | output | 1 | Acknowledge choice for a receive command |
| cmd_data | output | 8 | Byte to send, or configuration word |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| res_code | output | 3 | Result class of the last run |
| res_count | output | MW | Messages completed in the last run |

## Verification
The sequencer's state is its message index, byte index and phase. A wrong value in any of them shows at the ports within one engine round trip. The next command strobe then carries the wrong byte, the wrong acknowledge bit or the wrong start/stop choice, or a received byte lands at the wrong buffer address. Errors in message advance appear as a missing or extra repeated start in the command stream, and as a wrong completed count on `done`. Errors in the idle or transfer timers appear as a `done` that arrives too early or never.

// File: rtl/i2c_msg_seq.sv
`timescale 1ns/1ps
module i2c_msg_seq #(
  parameter int MAX_MSGS = 4,
  parameter int MAX_LEN = 8,
  parameter int IDLE_TMO = 64,
  parameter int XFER_TMO = 512,
  parameter logic [7:0] CFG_WORD = 8'h05,
  localparam int LW = $clog2(MAX_LEN + 1),
  localparam int MW = $clog2(MAX_MSGS + 1),
  localparam int AW = $clog2(MAX_MSGS * MAX_LEN)
)(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   go,
  input  logic [MW-1:0]          num_msgs,
  input  logic [MAX_MSGS*7-1:0]  msg_addr,
  input  logic [MAX_MSGS-1:0]    msg_rd,
  input  logic [MAX_MSGS*LW-1:0] msg_len,
  input  logic                   buf_we,
  input  logic [AW-1:0]          buf_addr,
  input  logic [7:0]             buf_wdata,
  output logic [7:0]             buf_rdata,
  input  logic [7:0]             eng_status,
  input  logic                   eng_si,
  input  logic [7:0]             eng_rdata,
  output logic                   cmd_vld,
  output logic [2:0]             cmd_op,
  output logic                   cmd_ack,
  output logic [7:0]             cmd_data,
  output logic                   busy,
  output logic                   done,
  output logic [2:0]             res_code,
  output logic [MW-1:0]          res_count
);
  localparam int IW = $clog2(MAX_MSGS);
  localparam int DEPTH = MAX_MSGS * MAX_LEN;
  localparam int TMAX = (IDLE_TMO > XFER_TMO) ? IDLE_TMO : XFER_TMO;
  localparam int TW = $clog2(TMAX + 1);

  localparam logic [2:0] OP_NONE = 3'd0, OP_START = 3'd1, OP_SEND = 3'd2, OP_RECV = 3'd3,
                         OP_STOP = 3'd4, OP_RESET = 3'd5, OP_CFG = 3'd6;
  localparam logic [2:0] RC_OK = 3'd0, RC_BUSY = 3'd1, RC_NODEV = 3'd2, RC_DNACK = 3'd3,
                         RC_EARLY = 3'd4, RC_ARB = 3'd5, RC_BUSERR = 3'd6, RC_TMO = 3'd7;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_RUN, S_CFG} st_t;
  st_t st;

  logic [MW-1:0] msg;
  logic [LW-1:0] nb;
  logic [TW-1:0] tmr;
  logic [7:0]    mem [DEPTH];

  logic [IW-1:0] mi;
  logic [6:0]    m_addr;
  logic          m_rd;
  logic [LW-1:0] m_len;
  logic [AW-1:0] ptr;
  logic [LW:0]   nb_p1, nb_p2;
  logic [MW-1:0] msg_p1;
  logic          last;

  assign mi     = msg[IW-1:0];
  assign m_addr = msg_addr[7*mi +: 7];
  assign m_rd   = msg_rd[mi];
  assign m_len  = msg_len[LW*mi +: LW];
  assign ptr    = AW'(mi * MAX_LEN) + AW'(nb);
  assign nb_p1  = {1'b0, nb} + 1'b1;
  assign nb_p2  = {1'b0, nb} + 2'd2;
  assign msg_p1 = msg + 1'b1;
  assign last   = (msg_p1 == num_msgs);
  assign busy   = (st != S_IDLE);
  assign buf_rdata = mem[buf_addr];

  logic [2:0] n_op, n_code;
  logic       n_ack, n_adv, n_inc, n_fin, n_cfg, n_store;
  logic [7:0] n_data;

  always_comb begin
    n_op = OP_NONE; n_ack = 1'b0; n_data = 8'h00; n_code = RC_OK;
    n_adv = 1'b0; n_inc = 1'b0; n_fin = 1'b0; n_cfg = 1'b0; n_store = 1'b0;
    case (eng_status)
      8'h08, 8'h10: begin n_op = OP_SEND; n_data = {m_addr, m_rd}; end
      8'h18, 8'h28:
        if (nb < m_len) begin n_op = OP_SEND; n_data = mem[ptr]; n_inc = 1'b1; end
        else n_adv = 1'b1;
      8'h40: begin n_op = OP_RECV; n_ack = (m_len > LW'(1)); end
      8'h50:
        if (nb < m_len) begin
          n_op = OP_RECV; n_store = 1'b1; n_inc = 1'b1;
          n_ack = (nb_p2 < {1'b0, m_len});
        end else n_adv = 1'b1;
      8'h58:
        if (nb_p1 == {1'b0, m_len}) begin n_store = 1'b1; n_adv = 1'b1; end
        else begin n_op = OP_STOP; n_fin = 1'b1; n_code = RC_EARLY; end
      8'h20, 8'h48: begin n_op = OP_STOP; n_fin = 1'b1; n_code = RC_NODEV; end
      8'h30:        begin n_op = OP_STOP; n_fin = 1'b1; n_code = RC_DNACK; end
      8'h38:        begin n_op = OP_START; n_fin = 1'b1; n_code = RC_ARB; end
      8'h00, 8'h70, 8'h78, 8'h90: begin n_op = OP_RESET; n_cfg = 1'b1; end
      default: ;
    endcase
    if (n_adv) begin
      n_op  = last ? OP_STOP : OP_START;
      n_fin = last;
    end
  end

  always_ff @(posedge clk) begin
    if (buf_we && !busy) mem[buf_addr] <= buf_wdata;
    else if (st == S_RUN && eng_si && n_store) mem[ptr] <= eng_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; msg <= '0; nb <= '0; tmr <= '0;
      cmd_vld <= 1'b0; cmd_op <= OP_NONE; cmd_ack <= 1'b0; cmd_data <= 8'h00;
      done <= 1'b0; res_code <= RC_OK; res_count <= '0;
    end else begin
      cmd_vld <= 1'b0;
      done    <= 1'b0;
      case (st)
        S_IDLE: if (go) begin
          st <= S_WAIT; tmr <= '0; msg <= '0; nb <= '0;
        end
        S_WAIT:
          if (eng_status == 8'hF8) begin
            if (num_msgs == '0) begin
              st <= S_IDLE; done <= 1'b1; res_code <= RC_OK; res_count <= '0;
            end else begin
              cmd_vld <= 1'b1; cmd_op <= OP_START; st <= S_RUN; tmr <= '0;
            end
          end else if (tmr == TW'(IDLE_TMO - 1)) begin
            st <= S_IDLE; done <= 1'b1; res_code <= RC_BUSY; res_count <= '0;
          end else tmr <= tmr + 1'b1;
        S_RUN: begin
          tmr <= tmr + 1'b1;
          if (eng_si) begin
            if (n_op != OP_NONE) begin
              cmd_vld <= 1'b1; cmd_op <= n_op; cmd_ack <= n_ack; cmd_data <= n_data;
            end
            if (n_inc) nb <= nb + 1'b1;
            if (n_adv) begin msg <= msg_p1; nb <= '0; end
            if (n_cfg) st <= S_CFG;
            if (n_fin) begin
              st <= S_IDLE; done <= 1'b1; res_code <= n_code;
              res_count <= n_adv ? msg_p1 : msg;
            end
          end else if (tmr == TW'(XFER_TMO - 1)) begin
            st <= S_IDLE; done <= 1'b1; res_code <= RC_TMO; res_count <= msg;
          end
        end
        S_CFG: begin
          cmd_vld <= 1'b1; cmd_op <= OP_CFG; cmd_data <= CFG_WORD;
          st <= S_IDLE; done <= 1'b1; res_code <= RC_BUSERR; res_count <= msg;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R11
  reset_then_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && cmd_op == OP_RESET) |=> (cmd_vld && cmd_op == OP_CFG && cmd_data == CFG_WORD));

  // R13
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R13
  done_ends_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  // R12
  data_cmd_from_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && (cmd_op == OP_SEND || cmd_op == OP_RECV)) |-> $past(eng_si));

  // R5
  ok_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && res_code == RC_OK) |-> (res_count == num_msgs));
endmodule

// File: tb/i2c_msg_seq_tb.sv
`timescale 1ns/1ps
module i2c_msg_seq_tb_top;
  localparam int MAX_MSGS = 4, MAX_LEN = 8, IDLE_TMO = 64, XFER_TMO = 512;
  localparam int LW = 4, MW = 3, AW = 5;

  logic clk = 1'b0, rst_n = 1'b0, go = 1'b0;
  logic [MW-1:0] num_msgs = '0;
  logic [MAX_MSGS*7-1:0] msg_addr = '0;
  logic [MAX_MSGS-1:0] msg_rd = '0;
  logic [MAX_MSGS*LW-1:0] msg_len = '0;
  logic buf_we = 1'b0;
  logic [AW-1:0] buf_addr = '0;
  logic [7:0] buf_wdata = '0, buf_rdata;
  logic [7:0] eng_status = 8'hF8, eng_rdata = 8'h00;
  logic eng_si = 1'b0;
  logic cmd_vld, cmd_ack, busy, done;
  logic [2:0] cmd_op, res_code;
  logic [7:0] cmd_data;
  logic [MW-1:0] res_count;

  always #4 clk = ~clk;

  i2c_msg_seq dut_i (
    .clk(clk), .rst_n(rst_n), .go(go), .num_msgs(num_msgs), .msg_addr(msg_addr),
    .msg_rd(msg_rd), .msg_len(msg_len), .buf_we(buf_we), .buf_addr(buf_addr),
    .buf_wdata(buf_wdata), .buf_rdata(buf_rdata), .eng_status(eng_status),
    .eng_si(eng_si), .eng_rdata(eng_rdata), .cmd_vld(cmd_vld), .cmd_op(cmd_op),
    .cmd_ack(cmd_ack), .cmd_data(cmd_data), .busy(busy), .done(done),
    .res_code(res_code), .res_count(res_count));

  int nchk = 0, nerr = 0;
  bit finished = 0;
  int log_op [64];
  int log_dat [64];
  int log_ack [64];
  int nlog = 0, ncmd = 0, rcnt = 0, wcnt = 0, pend = 0;
  int inj_idx = -1, nack_idx = 99;
  logic [7:0] inj_code = 8'h00, presp = 8'hF8, prdata = 8'h00;
  logic [6:0] dev_addr = 7'h50;
  bit started = 0, aphase = 0;
  int rc, rn, cyc;

  // behavioural engine
  always @(negedge clk) begin
    logic [7:0] resp;
    bit give;
    eng_si = 1'b0;
    if (pend > 0) begin
      pend--;
      if (pend == 0) begin eng_status = presp; eng_rdata = prdata; eng_si = 1'b1; end
    end
    if (cmd_vld) begin
      if (nlog < 64) begin
        log_op[nlog] = int'(cmd_op); log_dat[nlog] = int'(cmd_data); log_ack[nlog] = int'(cmd_ack);
        nlog++;
      end
      give = 1'b1; resp = 8'hF8;
      case (cmd_op)
        3'd1: begin resp = started ? 8'h10 : 8'h08; started = 1; aphase = 1; end
        3'd2: if (aphase) begin
                aphase = 0; wcnt = 0;
                if (cmd_data[7:1] == dev_addr) resp = cmd_data[0] ? 8'h40 : 8'h18;
                else resp = cmd_data[0] ? 8'h48 : 8'h20;
              end else begin
                resp = (wcnt == nack_idx) ? 8'h30 : 8'h28; wcnt++;
              end
        3'd3: begin prdata = 8'hC0 + 8'(rcnt); rcnt++; resp = cmd_ack ? 8'h50 : 8'h58; end
        3'd4, 3'd5: begin eng_status = 8'hF8; started = 0; give = 0; end
        default: give = 0;
      endcase
      if (give) begin
        if (ncmd == inj_idx) resp = inj_code;
        presp = resp; pend = 2;
      end
      ncmd++;
    end
  end

  task automatic check(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic setup(int n);
    repeat (4) @(negedge clk);
    nlog = 0; ncmd = 0; rcnt = 0; pend = 0; started = 0; aphase = 0;
    inj_idx = -1; nack_idx = 99; dev_addr = 7'h50; eng_status = 8'hF8;
    num_msgs = MW'(n);
  endtask

  task automatic set_msg(int i, logic [6:0] a, logic rd, int len);
    msg_addr[i*7 +: 7] = a; msg_rd[i] = rd; msg_len[i*LW +: LW] = LW'(len);
  endtask

  task automatic wbuf(int a, logic [7:0] d);
    @(negedge clk); buf_we = 1'b1; buf_addr = AW'(a); buf_wdata = d;
    @(negedge clk); buf_we = 1'b0;
  endtask

  task automatic rbuf(int a, output int d);
    buf_addr = AW'(a); #1; d = int'(buf_rdata);
  endtask

  task automatic run_xfer();
    @(negedge clk) go = 1'b1;
    @(negedge clk) go = 1'b0;
    cyc = 1;
    while (!done && cyc < 3000) begin @(negedge clk); cyc++; end
    check("R13 done seen", int'(done), 1);
    rc = int'(res_code); rn = int'(res_count);
    @(negedge clk);
    check("R13 done one cycle", int'(done), 0);
    check("R13 result held", int'(res_code), rc);
  endtask

  task automatic t_reset();
    check("R1 busy", int'(busy), 0);
    check("R1 done", int'(done), 0);
    check("R1 cmd_vld", int'(cmd_vld), 0);
    check("R1 res_code", int'(res_code), 0);
    check("R1 res_count", int'(res_count), 0);
  endtask

  task automatic t_write_read();
    int d;
    setup(2);
    set_msg(0, 7'h50, 0, 3); set_msg(1, 7'h50, 1, 2);
    wbuf(0, 8'h11); wbuf(1, 8'h22); wbuf(2, 8'h33);
    run_xfer();
    check("R5 code ok", rc, 0); check("R5 count", rn, 2);
    check("R5 nlog", nlog, 10);
    check("R3 first start", log_op[0], 1);
    check("R3 addr write", log_dat[1], 8'hA0);
    check("R4 byte0", log_dat[2], 8'h11);
    check("R4 byte2", log_dat[4], 8'h33);
    check("R5 repeated start", log_op[5], 1);
    check("R3 addr read", log_dat[6], 8'hA1);
    check("R6 ack first", log_ack[7], 1);
    check("R6 nack last op", log_op[8], 3);
    check("R6 nack last", log_ack[8], 0);
    check("R5 stop", log_op[9], 4);
    rbuf(8, d); check("R6 stored b0", d, 8'hC0);
    rbuf(9, d); check("R6 stored b1", d, 8'hC1);
  endtask

  task automatic t_zero_len();
    setup(2);
    set_msg(0, 7'h50, 0, 0); set_msg(1, 7'h50, 0, 1);
    wbuf(8, 8'h44);
    run_xfer();
    check("R4 zl code", rc, 0); check("R4 zl count", rn, 2);
    check("R4 zl nlog", nlog, 6);
    check("R4 zl restart", log_op[2], 1);
    check("R4 zl data", log_dat[4], 8'h44);
    check("R4 zl stop", log_op[5], 4);
  endtask

  task automatic t_reads();
    int d;
    setup(2);
    set_msg(0, 7'h50, 1, 3); set_msg(1, 7'h50, 1, 1);
    run_xfer();
    check("R6 rd code", rc, 0); check("R6 rd nlog", nlog, 9);
    check("R6 ack0", log_ack[2], 1); check("R6 ack1", log_ack[3], 1);
    check("R6 ack2", log_ack[4], 0);
    check("R6 len1 nack", log_ack[7], 0); check("R6 len1 op", log_op[7], 3);
    rbuf(2, d); check("R6 rd b2", d, 8'hC2);
    rbuf(8, d); check("R6 len1 byte", d, 8'hC3);
  endtask

  task automatic t_addr_nack();
    setup(2);
    set_msg(0, 7'h50, 0, 1); set_msg(1, 7'h33, 0, 2);
    run_xfer();
    check("R8 code", rc, 2); check("R8 count", rn, 1);
    check("R8 nlog", nlog, 6); check("R8 addr", log_dat[4], 8'h66);
    check("R8 stop", log_op[5], 4);
  endtask

  task automatic t_data_nack();
    setup(1);
    set_msg(0, 7'h50, 0, 3); nack_idx = 1;
    run_xfer();
    check("R9 code", rc, 3); check("R9 count", rn, 0);
    check("R9 nlog", nlog, 5); check("R9 stop", log_op[4], 4);
  endtask

  task automatic t_early_nack();
    int d;
    setup(1);
    set_msg(0, 7'h50, 1, 3);
    wbuf(0, 8'h5A);
    inj_idx = 2; inj_code = 8'h58;
    run_xfer();
    check("R7 code", rc, 4); check("R7 nlog", nlog, 4);
    check("R7 stop", log_op[3], 4);
    rbuf(0, d); check("R7 byte not stored", d, 8'h5A);
  endtask

  task automatic t_arb();
    setup(1);
    set_msg(0, 7'h50, 0, 2);
    inj_idx = 1; inj_code = 8'h38;
    run_xfer();
    check("R10 code", rc, 5); check("R10 nlog", nlog, 3);
    check("R10 start", log_op[2], 1);
  endtask

  task automatic t_buserr(int at, logic [7:0] code);
    setup(1);
    set_msg(0, 7'h50, 0, 2);
    inj_idx = at; inj_code = code;
    run_xfer();
    check("R11 code", rc, 6); check("R11 nlog", nlog, at + 3);
    check("R11 reset", log_op[at + 1], 5);
    check("R11 cfg", log_op[at + 2], 6);
    check("R11 cfg word", log_dat[at + 2], 8'h05);
  endtask

  task automatic t_idle_tmo();
    setup(1);
    set_msg(0, 7'h50, 0, 1);
    eng_status = 8'hE0;
    run_xfer();
    check("R2 busy code", rc, 1); check("R2 busy count", rn, 0);
    check("R2 no cmd", nlog, 0);
    check("R2 waited", int'(cyc >= IDLE_TMO), 1);
  endtask

  task automatic t_idle_late();
    setup(1);
    set_msg(0, 7'h50, 0, 1);
    eng_status = 8'hE0;
    fork
      run_xfer();
      begin repeat (20) @(negedge clk); eng_status = 8'hF8; end
    join
    check("R2 late idle code", rc, 0); check("R2 late idle nlog", nlog, 4);
  endtask

  task automatic t_unknown();
    setup(1);
    set_msg(0, 7'h50, 0, 2);
    inj_idx = 1; inj_code = 8'hE0;
    run_xfer();
    check("R12 code", rc, 7); check("R12 no cmd", nlog, 2);
    check("R12 waited", int'(cyc >= XFER_TMO), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_write_read();
    t_zero_len();
    t_reads();
    t_addr_nack();
    t_data_nack();
    t_early_nack();
    t_arb();
    t_buserr(0, 8'h90);
    t_buserr(2, 8'h00);
    t_idle_tmo();
    t_idle_late();
    t_unknown();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nchk++; nerr++;
      $display("FAIL R13 watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end
endmodule